// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind the byte-level slave of a two-wire serial memory and handles the write path. Once the slave has taken the device word and the memory address, it opens a transfer with the start address. Each received data byte is then placed in a 16-entry page latch. A 16-bit mark vector records which columns hold new data.

A stop condition ends the transfer. If marked bytes are present and the transfer was not refused, the block starts a write cycle that the bus cannot interrupt. In that cycle it scans the 16 columns, one per clock, and sends each marked byte to a synchronous byte RAM port. It then holds busy for a fixed programming time, set by a parameter in system-clock cycles. During the whole cycle, bus traffic is ignored.

For every data byte the block returns an accept flag, which becomes the acknowledge. On every stop it reports the final address, so the slave can update its current-address counter. The write-protect input is sampled at each data byte. It must be tied low when it is not used, and low allows writes to every location.

Top module: `pgwr_engine`

## Requirements
- R1: While reset is held and after it is released, busy_o, ack_vld_o, fin_vld_o and mem_we_o are all low.
- R2: An open pulse starts a transfer at open_addr_i. A data byte taken while a transfer is live and wp_i is low is stored at the current column. One cycle later the block gives an ack_vld_o pulse with ack_ok_o high.
- R3: After each data byte only the column (address bits 3..0) increments. Column 15 wraps to column 0 of the same page, and the upper bits 10..4 stay fixed. A later byte at a column replaces the earlier one.
- R4: A stop with at least one marked byte raises busy_o on the next cycle. The block then spends 16 cycles scanning columns 0 to 15 in order and asserts mem_we_o only for marked columns. The address is {page, column} and the data is the latest byte stored at that column.
- R5: busy_o stays high for exactly 16 + WC_CYCLES cycles and then falls.
- R6: While busy_o is high, open, data-byte and stop inputs have no effect: no ack pulse, no final-address pulse and no change to later behaviour.
- R7: A data byte taken with wp_i high is answered with ack_ok_o low. The latch is cleared, every later byte of the same transfer is refused, and the stop that ends the transfer neither writes nor raises busy_o.
- R8: A stop with no marked bytes does not raise busy_o and issues no memory write.
- R9: Every stop that ends a live transfer gives a one-cycle fin_vld_o pulse. fin_addr_o is {page, column after the last byte}, with the column wrapping inside the page.
- R10: A data byte and a stop in the same cycle: the byte is acknowledged and is part of the commit.
- R11: Data bytes and stops with no live transfer are ignored. A new open discards bytes latched by an earlier unfinished transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| open_i | input | 1 | Start of a write transfer, one-cycle pulse |
| open_addr_i | input | ADDR_W | Start memory address of the transfer |
| byte_vld_i | input | 1 | One received data byte, one-cycle pulse |
| byte_data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Stop condition, one-cycle pulse |
| wp_i | input | 1 | Write protect, high refuses data; tie low when unused |
| ack_vld_o | output | 1 | Accept result of the previous cycle's byte is valid |
| ack_ok_o | output | 1 | Byte accepted (drives acknowledge low) |
| busy_o | output | 1 | Internal write cycle in progress |
| fin_vld_o | output | 1 | Final address is valid, one-cycle pulse |
| fin_addr_o | output | ADDR_W | Address following the last byte of the transfer |
| mem_we_o | output | 1 | Array byte write enable |
| mem_addr_o | output | ADDR_W | Array byte address |
| mem_wdata_o | output | DATA_W | Array byte write data |

## Verification
The same-cycle case studied is a data byte together with the stop that ends its transfer. The byte has to be acknowledged, latched and included in the commit that the same stop launches. It must also advance the column reported as the final address. The bench provokes this with and without earlier bytes, and once with write protect high in that cycle. Every cycle it compares ack, busy, final address and memory port against a behavioural model, and at the end it compares the whole array image.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_DRAIN = 2'd1,
        CM_HOLD  = 2'd2
    } cm_state_e;

endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [COL_W-1:0]  wcol_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [COL_W-1:0]  rcol_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rmark_o,
    output logic              any_o
);
    localparam int COLS = 1 << COL_W;

    typedef struct packed {
        logic [COLS-1:0][DATA_W-1:0] data;
        logic [COLS-1:0]             mark;
    } lat_t;

    lat_t s_d, s_q;
    logic [COLS-1:0] hit;

    for (genvar gi = 0; gi < COLS; gi++) begin : g_col
        assign hit[gi] = we_i && (wcol_i == COL_W'(gi));
    end

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.mark = '0;
        end else begin
            for (int i = 0; i < COLS; i++) begin
                if (hit[i]) begin
                    s_d.data[i] = wdata_i;
                    s_d.mark[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o = s_q.data[rcol_i];
    assign rmark_o = s_q.mark[rcol_i];
    assign any_o   = |s_q.mark;

    // R7: a clear empties the mark vector
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.mark == '0));

    // R2: a written column is marked afterwards
    p_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> s_q.mark[$past(wcol_i)]);

endmodule

// File: rtl/pgwr_front.sv
module pgwr_front #(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy_i,
    input  logic                    open_i,
    input  logic [ADDR_W-1:0]       open_addr_i,
    input  logic                    byte_vld_i,
    input  logic                    wp_i,
    input  logic                    stop_i,
    input  logic                    mark_any_i,
    output logic                    lat_we_o,
    output logic                    lat_clr_o,
    output logic [COL_W-1:0]        lat_col_o,
    output logic [ADDR_W-COL_W-1:0] page_o,
    output logic                    launch_o,
    output logic                    ack_vld_o,
    output logic                    ack_ok_o,
    output logic                    fin_vld_o,
    output logic [ADDR_W-1:0]       fin_addr_o
);
    localparam int PG_W = ADDR_W - COL_W;

    typedef struct packed {
        logic              live;
        logic              blk;
        logic [PG_W-1:0]   page;
        logic [COL_W-1:0]  col;
        logic              ackv;
        logic              acko;
        logic              finv;
        logic [ADDR_W-1:0] fina;
    } fr_t;

    fr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ackv = 1'b0;
        s_d.acko = 1'b0;
        s_d.finv = 1'b0;
        lat_we_o  = 1'b0;
        lat_clr_o = 1'b0;
        launch_o  = 1'b0;
        if (!busy_i) begin
            if (open_i) begin
                s_d.live  = 1'b1;
                s_d.blk   = 1'b0;
                s_d.page  = open_addr_i[ADDR_W-1:COL_W];
                s_d.col   = open_addr_i[COL_W-1:0];
                lat_clr_o = 1'b1;
            end else if (s_q.live) begin
                if (byte_vld_i) begin
                    s_d.ackv = 1'b1;
                    if (wp_i) begin
                        s_d.blk   = 1'b1;
                        lat_clr_o = 1'b1;
                    end else if (!s_q.blk) begin
                        s_d.acko = 1'b1;
                        lat_we_o = 1'b1;
                    end
                    s_d.col = s_q.col + COL_W'(1);
                end
                if (stop_i) begin
                    s_d.live = 1'b0;
                    s_d.finv = 1'b1;
                    s_d.fina = {s_q.page, s_d.col};
                    launch_o = !s_d.blk && (mark_any_i || lat_we_o);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lat_col_o  = s_q.col;
    assign page_o     = s_q.page;
    assign ack_vld_o  = s_q.ackv;
    assign ack_ok_o   = s_q.acko;
    assign fin_vld_o  = s_q.finv;
    assign fin_addr_o = s_q.fina;

    // R3: column wraps inside the page
    p_col_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !open_i && s_q.live && byte_vld_i && (s_q.col == '1))
        |=> (s_q.col == '0));

    // R7: a protected byte is answered with a refusal
    p_wp_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !open_i && s_q.live && byte_vld_i && wp_i)
        |=> (ack_vld_o && !ack_ok_o));

    // R11: no live transfer, no acknowledge
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.live && !open_i) |=> !ack_vld_o);

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int WC_CYCLES = 250000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch_i,
    input  logic [ADDR_W-COL_W-1:0] page_i,
    input  logic                    rmark_i,
    input  logic [DATA_W-1:0]       rdata_i,
    output logic                    busy_o,
    output logic [COL_W-1:0]        rcol_o,
    output logic                    done_clr_o,
    output logic                    mem_we_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [DATA_W-1:0]       mem_wdata_o
);
    localparam int PG_W  = ADDR_W - COL_W;
    localparam int CNT_W = $clog2(WC_CYCLES + 1);

    typedef struct packed {
        cm_state_e        st;
        logic [PG_W-1:0]  page;
        logic [COL_W-1:0] col;
        logic [CNT_W-1:0] cnt;
    } cm_t;

    cm_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        done_clr_o = 1'b0;
        case (s_q.st)
            CM_IDLE: begin
                if (launch_i) begin
                    s_d.st   = CM_DRAIN;
                    s_d.page = page_i;
                    s_d.col  = '0;
                    s_d.cnt  = '0;
                end
            end
            CM_DRAIN: begin
                s_d.col = s_q.col + COL_W'(1);
                if (s_q.col == '1) begin
                    s_d.st     = CM_HOLD;
                    s_d.cnt    = '0;
                    done_clr_o = 1'b1;
                end
            end
            CM_HOLD: begin
                if (s_q.cnt == CNT_W'(WC_CYCLES - 1)) s_d.st = CM_IDLE;
                else                                   s_d.cnt = s_q.cnt + CNT_W'(1);
            end
            default: s_d.st = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: CM_IDLE, page: '0, col: '0, cnt: '0};
        else        s_q <= s_d;
    end

    assign busy_o      = (s_q.st != CM_IDLE);
    assign rcol_o      = s_q.col;
    assign mem_we_o    = (s_q.st == CM_DRAIN) && rmark_i;
    assign mem_addr_o  = {s_q.page, s_q.col};
    assign mem_wdata_o = rdata_i;

    // R4: the scan stays in drain until the last column
    p_drain_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == CM_DRAIN && s_q.col != '1) |=> (s_q.st == CM_DRAIN));

    // R5: the hold phase lasts the full programming time
    p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == CM_HOLD && s_q.cnt != CNT_W'(WC_CYCLES - 1)) |=> (s_q.st == CM_HOLD));

    // R6: the committed page cannot change during a cycle
    p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != CM_IDLE) |=> $stable(s_q.page));

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
    parameter int ADDR_W    = 11,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int WC_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic [ADDR_W-1:0] open_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              ack_vld_o,
    output logic              ack_ok_o,
    output logic              busy_o,
    output logic              fin_vld_o,
    output logic [ADDR_W-1:0] fin_addr_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int PG_W = ADDR_W - COL_W;

    logic              lat_we, lat_clr_f, lat_clr_c, any_mark, rmark, launch;
    logic [COL_W-1:0]  wcol, rcol;
    logic [PG_W-1:0]   page;
    logic [DATA_W-1:0] rdata;

    pgwr_front #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_o),
        .open_i     (open_i),
        .open_addr_i(open_addr_i),
        .byte_vld_i (byte_vld_i),
        .wp_i       (wp_i),
        .stop_i     (stop_i),
        .mark_any_i (any_mark),
        .lat_we_o   (lat_we),
        .lat_clr_o  (lat_clr_f),
        .lat_col_o  (wcol),
        .page_o     (page),
        .launch_o   (launch),
        .ack_vld_o  (ack_vld_o),
        .ack_ok_o   (ack_ok_o),
        .fin_vld_o  (fin_vld_o),
        .fin_addr_o (fin_addr_o)
    );

    pgwr_latch #(.COL_W(COL_W), .DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (lat_clr_f || lat_clr_c),
        .we_i   (lat_we),
        .wcol_i (wcol),
        .wdata_i(byte_data_i),
        .rcol_i (rcol),
        .rdata_o(rdata),
        .rmark_o(rmark),
        .any_o  (any_mark)
    );

    pgwr_commit #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
                  .WC_CYCLES(WC_CYCLES)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .page_i     (page),
        .rmark_i    (rmark),
        .rdata_i    (rdata),
        .busy_o     (busy_o),
        .rcol_o     (rcol),
        .done_clr_o (lat_clr_c),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );

    // R4: array writes only inside a write cycle
    p_we_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R9: every write cycle begins with a final-address report
    p_launch_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> fin_vld_o);

    // R6: the bus side is silent while busy
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!ack_vld_o && !fin_vld_o));

endmodule

// File: tb/pgwr_engine_test.sv
`timescale 1ns/1ps
module pgwr_engine_test;
    localparam int AW = 11, CW = 4, DW = 8, WC = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op = 1'b0, bv = 1'b0, st = 1'b0, wp = 1'b0;
    logic [AW-1:0] oa = '0;
    logic [DW-1:0] bd = '0;
    logic ack_vld_o, ack_ok_o, busy_o, fin_vld_o, mem_we_o;
    logic [AW-1:0] fin_addr_o, mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    always #10 clk = ~clk;

    pgwr_engine #(.ADDR_W(AW), .COL_W(CW), .DATA_W(DW), .WC_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .open_i(op), .open_addr_i(oa),
        .byte_vld_i(bv), .byte_data_i(bd), .stop_i(st), .wp_i(wp),
        .ack_vld_o(ack_vld_o), .ack_ok_o(ack_ok_o), .busy_o(busy_o),
        .fin_vld_o(fin_vld_o), .fin_addr_o(fin_addr_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

    int vec_n = 0, bad_n = 0;
    bit [7:0] ram  [2048];
    bit [7:0] mmem [2048];

    always @(posedge clk) if (rst_n && mem_we_o) ram[mem_addr_o] <= mem_wdata_o;

    // behavioural reference
    bit m_live, m_blk, e_ackv, e_acko, e_finv, e_we;
    int m_page, m_col, m_k = -1, e_fina, e_addr;
    bit [7:0] m_lat [16];
    bit m_mk [16];
    bit [7:0] e_wd;

    function automatic bit any_mk();
        for (int i = 0; i < 16; i++) if (m_mk[i]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_live = 0; m_blk = 0; m_page = 0; m_col = 0; m_k = -1;
            e_ackv = 0; e_acko = 0; e_finv = 0; e_we = 0; e_fina = 0;
            for (int i = 0; i < 16; i++) m_mk[i] = 0;
        end else begin
            if (e_we) mmem[e_addr] = e_wd;
            e_ackv = 0; e_acko = 0; e_finv = 0;
            if (m_k >= 0) begin
                if (m_k == 15) for (int i = 0; i < 16; i++) m_mk[i] = 0;
                m_k++;
                if (m_k == 16 + WC) m_k = -1;
            end else if (op) begin
                m_live = 1; m_blk = 0; m_page = int'(oa) / 16; m_col = int'(oa) % 16;
                for (int i = 0; i < 16; i++) m_mk[i] = 0;
            end else if (m_live) begin
                if (bv) begin
                    e_ackv = 1;
                    if (wp) begin
                        m_blk = 1;
                        for (int i = 0; i < 16; i++) m_mk[i] = 0;
                    end else if (!m_blk) begin
                        e_acko = 1; m_lat[m_col] = bd; m_mk[m_col] = 1;
                    end
                    m_col = (m_col + 1) % 16;
                end
                if (st) begin
                    m_live = 0; e_finv = 1; e_fina = m_page * 16 + m_col;
                    if (!m_blk && any_mk()) m_k = 0;
                end
            end
            e_we = (m_k >= 0 && m_k < 16) ? m_mk[m_k] : 1'b0;
            if (e_we) begin e_addr = m_page * 16 + m_k; e_wd = m_lat[m_k]; end
        end
    end

    always @(negedge clk) if (rst_n) begin
        bit bad;
        bad = 0; vec_n++;
        if (busy_o !== (m_k >= 0)) begin bad = 1;
            $display("FAIL R5 busy_o actual=%b expected=%b", busy_o, m_k >= 0); end
        if (ack_vld_o !== e_ackv) begin bad = 1;
            $display("FAIL R2 ack_vld_o actual=%b expected=%b", ack_vld_o, e_ackv); end
        if (e_ackv && ack_ok_o !== e_acko) begin bad = 1;
            $display("FAIL R7 ack_ok_o actual=%b expected=%b", ack_ok_o, e_acko); end
        if (fin_vld_o !== e_finv) begin bad = 1;
            $display("FAIL R8 fin_vld_o actual=%b expected=%b", fin_vld_o, e_finv); end
        if (e_finv && fin_addr_o !== AW'(e_fina)) begin bad = 1;
            $display("FAIL R9 fin_addr_o actual=%h expected=%h", fin_addr_o, e_fina); end
        if (mem_we_o !== e_we) begin bad = 1;
            $display("FAIL R4 mem_we_o actual=%b expected=%b", mem_we_o, e_we); end
        if (e_we && (mem_addr_o !== AW'(e_addr) || mem_wdata_o !== e_wd)) begin bad = 1;
            $display("FAIL R3 mem addr/data actual=%h/%h expected=%h/%h",
                     mem_addr_o, mem_wdata_o, e_addr, e_wd); end
        if (bad) bad_n++;
    end

    task automatic drive(bit o, int a, bit b, int d, bit w, bit s);
        @(negedge clk);
        op = o; oa = AW'(a); bv = b; bd = DW'(d); wp = w; st = s;
    endtask
    task automatic t_idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask
    task automatic t_open(int a);          drive(1, a, 0, 0, 0, 0); endtask
    task automatic t_byte(int d, bit w);   drive(0, 0, 1, d, w, 0); endtask
    task automatic t_stop();               drive(0, 0, 0, 0, 0, 1); endtask
    task automatic t_bstop(int d, bit w);  drive(0, 0, 1, d, w, 1); endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad_n++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        vec_n++;
        if (busy_o || ack_vld_o || fin_vld_o || mem_we_o) begin
            bad_n++;
            $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0000",
                     busy_o, ack_vld_o, fin_vld_o, mem_we_o);
        end
        rst_n = 1'b1;
        t_idle(3);
        // R2 R4 R5: single byte
        t_open('h123); t_byte('hA5, 0); t_stop(); t_idle(45);
        // R3: wrap from column 14, five bytes, R9 final address wraps
        t_open('h2FE);
        for (int i = 0; i < 5; i++) t_byte('h10 + i, 0);
        t_stop(); t_idle(45);
        // R3: twenty bytes overwrite the first four
        t_open('h540);
        for (int i = 0; i < 20; i++) t_byte('h60 + i, 0);
        t_stop();
        // R6: traffic during the write cycle is ignored
        t_idle(2); t_open('h700); t_byte('hEE, 0); t_stop(); t_idle(45);
        // R11: bytes with no live transfer
        t_byte('h33, 0); t_stop(); t_idle(2);
        // R7: protected byte mid transfer, later bytes refused
        t_open('h3A0); t_byte('h01, 0); t_byte('h02, 1); t_byte('h03, 0); t_stop(); t_idle(4);
        // R8: dummy write, no commit
        t_open('h412); t_stop(); t_idle(4);
        // R10: byte with stop in the same cycle, alone and after others
        t_open('h0C5); t_bstop('h77, 0); t_idle(45);
        t_open('h6AF); t_byte('h81, 0); t_bstop('h82, 0); t_idle(45);
        t_open('h150); t_byte('h91, 0); t_bstop('h92, 1); t_idle(4);
        // R11: new open discards earlier unfinished bytes
        t_open('h220); t_byte('hC1, 0); t_byte('hC2, 0);
        t_open('h228); t_byte('hD1, 0); t_stop(); t_idle(45);
        // R4: array image
        for (int a = 0; a < 2048; a++) begin
            vec_n++;
            if (ram[a] !== mmem[a]) begin
                bad_n++;
                $display("FAIL R4 array[%0h] actual=%h expected=%h", a, ram[a], mmem[a]);
            end
        end
        finish_run();
    end
endmodule